// File: doc/BRIEF.md
# Tamper-Monitoring Backup GPIO Controller

This block watches eight backup I/O pins. Each pin works either as a plain GPIO or as a tamper input. As a tamper input, the pin raises a latched alarm when its level stays away from a programmed resting level for long enough. Two more event sources are latched next to the pin alarms: a debug-port activity input and a factory-test-pin input.

Software drives the block over a simple register bus. The bus has a write strobe, a read strobe, a byte address and 32-bit data. Read data appears one clock after the read strobe. A level-high interrupt stays asserted while any enabled alarm is latched. A one-cycle wake-up pulse marks a new pin alarm on a pin that has wake-up enabled.

A keyed mode register selects normal or backup mode. Each mode has its own set of per-pin detect enables, so a pin can be watched in one mode and ignored in the other. Reset is asynchronous and active low, and it is released on the clock.

Top module: `tamper_gpio_monitor`

## Requirements
- R1: After reset the block is in normal mode (`backup_mode`=0, offset 0x00 reads 0x2). The status (0x08), interrupt mask (0x8C), normal detect enable (0x80), backup detect enable (0x7C) and wake-up enable (0x90) registers all read zero. Every pin is an input (`pad_oe`=0), and `irq` and `wakeup` are low.
- R2: A write to offset 0x00 changes the mode only when data bits 31:16 equal 0x89CA. With the key, bit 1 selects normal mode and takes priority, and bit 0 selects backup mode. A write with the wrong key leaves the mode unchanged. A read of 0x00 returns bit 0 = backup and bit 1 = normal.
- R3: The register for pin n is at offset 0x18+4n and holds these fields:
  - bits 3:0: filter count
  - bits 7:4: spare filter value
  - bit 8: output enable, driven on `pad_oe[n]`
  - bit 9: output level, driven on `pad_out[n]`
  - bits 13:12: pull mode, driven on `pad_pull[2n+1:2n]`
  - bit 15: default level

  Bits 11, 14 and 31:16 read as zero.
- R4: Bit 10 of a pin register is read-only. It returns the pad level after a two-flop synchronizer, so a read issued at the second rising edge after a pad change still returns the old level.
- R5: A pin alarm sets status bit 16+n after the synchronized level has differed from the default level for 2^F consecutive cycles, where F is the filter count. The bit becomes visible 2+2^F clock edges after the pad changes. A shorter excursion raises no alarm.
- R6: After an alarm, a pin raises no new alarm until its level has returned to the default level.
- R7: Detection runs only on input pins whose detect enable is set for the current mode: offset 0x80 bits 16+n in normal mode, offset 0x7C bits 16+n in backup mode.
- R8: Status bits are sticky. Writing 1 to offset 0x10 bit 16+n clears pin n, bit 3 clears the debug event and bit 2 clears the test-pin event.
- R9: Writing 1 to bit 16+n at offset 0x84 sets mask bit n, and writing 1 at offset 0x88 clears it. Offset 0x8C reads the mask at bits 16+n.
- R10: `irq` is high while any pin status bit with its mask bit set is latched, or while the debug or test-pin status bit is set.
- R11: Writing 1 to offset 0x68 bit 0 sets a sticky debug-lock bit, which reads back at bit 0 and cannot be cleared by a write. While the lock is set, `jtag_activity` sets status bit 3. `test_tamper` always sets status bit 2.
- R12: `wakeup` pulses for exactly one cycle, in the cycle where a pin alarm latches, when that pin's bit 16+n at offset 0x90 is set. Otherwise it stays low.
- R13: Reads of offsets the block does not map, and of the write-only offsets 0x10, 0x84 and 0x88, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Driven output levels |
| pad_oe | output | 8 | Per-pin output enables |
| pad_pull | output | 16 | Pull mode, two bits per pin |
| jtag_activity | input | 1 | Debug-port activity indication |
| test_tamper | input | 1 | Factory test pin tamper indication |
| backup_mode | output | 1 | High in backup mode |
| irq | output | 1 | Level-high interrupt |
| wakeup | output | 1 | One-cycle wake-up pulse |

## Verification
Each result arrives a fixed number of cycles after its stimulus:

- Read data is due one edge after the read strobe.
- Register writes reach `irq`, `pad_oe` and the mode one edge after the write strobe.
- The pad readback reflects a change after two edges.
- A pin alarm shows on `irq` and `wakeup` 2+2^F edges after the pad change.
- A debug or test-pin event shows three edges after its input rises.

Reads go through a queue of expected words. A monitor compares the queue against the read data at the falling edge after the read was captured. Timing-sensitive outputs are sampled at exact falling-edge counts from the stimulus: one edge before the due cycle (expecting the old value) and at the due cycle (expecting the new one), so an off-by-one in the synchronizer or filter is caught.

// File: rtl/tgm_pkg.sv
package tgm_pkg;
  parameter int TGM_NPINS  = 8;
  parameter int TGM_FILT_W = 4;
  parameter int TGM_PULL_W = 2;
  parameter int TGM_ADDR_W = 8;
  parameter int TGM_DATA_W = 32;

  // Register offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_CLR   = 'h10;
  localparam int OFF_PIN0  = 'h18;
  localparam int OFF_DLOCK = 'h68;
  localparam int OFF_DETB  = 'h7C;
  localparam int OFF_DETN  = 'h80;
  localparam int OFF_MSET  = 'h84;
  localparam int OFF_MCLR  = 'h88;
  localparam int OFF_MASK  = 'h8C;
  localparam int OFF_WAKE  = 'h90;

  localparam logic [15:0] MODE_KEY = 16'h89CA;
  localparam int KEY_LSB   = 16;
  localparam int BKP_BIT   = 0;
  localparam int NORM_BIT  = 1;
  localparam int PIN_LSB   = 16;
  localparam int DBG_BIT   = 3;
  localparam int TST_BIT   = 2;

  // Per-pin word field positions
  localparam int FA_LSB    = 0;
  localparam int FB_LSB    = 4;
  localparam int DIR_BIT   = 8;
  localparam int LVL_BIT   = 9;
  localparam int PAD_BIT   = 10;
  localparam int PULL_LSB  = 12;
  localparam int DFLT_BIT  = 15;

  typedef struct packed {
    logic                  dflt;
    logic [TGM_PULL_W-1:0] pull;
    logic                  lvl;
    logic                  dir;
    logic [TGM_FILT_W-1:0] fb;
    logic [TGM_FILT_W-1:0] fa;
  } tgm_pin_cfg_t;
endpackage

// File: rtl/tgm_sync.sv
module tgm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/tgm_pin_filter.sv
module tgm_pin_filter #(
  parameter int FILT_W = 4,
  localparam int CNT_W = 1 << FILT_W
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              enable,
  input  logic              level,
  input  logic              deflt,
  input  logic [FILT_W-1:0] filt,
  output logic              alarm
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             fired_q, fired_d;
  logic             mismatch;

  assign mismatch = enable && (level != deflt);
  assign limit    = (CNT_W'(1) << filt) - CNT_W'(1);
  assign alarm    = mismatch && !fired_q && (cnt_q == limit);

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (!mismatch || fired_q || alarm) cnt_d = '0;
    else                               cnt_d = cnt_q + CNT_W'(1);
    if (level == deflt) fired_d = 1'b0;
    else if (alarm)     fired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
    end
  end
endmodule

// File: rtl/tgm_alarm_ctrl.sv
module tgm_alarm_ctrl #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [NPINS-1:0] pin_alarm,
  input  logic             dbg_evt,
  input  logic             tst_evt,
  input  logic [NPINS-1:0] clr_pins,
  input  logic             clr_dbg,
  input  logic             clr_tst,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wake_en,
  output logic [NPINS-1:0] st_pins,
  output logic             st_dbg,
  output logic             st_tst,
  output logic             irq,
  output logic             wakeup
);
  logic [NPINS-1:0] pins_q, pins_d;
  logic             dbg_q, dbg_d, tst_q, tst_d, wake_q, wake_d;

  always_comb begin
    // a new event wins over a clear in the same cycle
    pins_d = (pins_q & ~clr_pins) | pin_alarm;
    dbg_d  = (dbg_q & ~clr_dbg) | dbg_evt;
    tst_d  = (tst_q & ~clr_tst) | tst_evt;
    wake_d = |(pin_alarm & wake_en);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pins_q <= '0;
      dbg_q  <= 1'b0;
      tst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      pins_q <= pins_d;
      dbg_q  <= dbg_d;
      tst_q  <= tst_d;
      wake_q <= wake_d;
    end
  end

  assign st_pins = pins_q;
  assign st_dbg  = dbg_q;
  assign st_tst  = tst_q;
  assign irq     = (|(pins_q & mask)) | dbg_q | tst_q;
  assign wakeup  = wake_q;
endmodule

// File: rtl/tamper_gpio_monitor.sv
module tamper_gpio_monitor
  import tgm_pkg::*;
#(
  parameter int NPINS  = TGM_NPINS,
  parameter int FILT_W = TGM_FILT_W,
  parameter int PULL_W = TGM_PULL_W,
  parameter int ADDR_W = TGM_ADDR_W,
  parameter int DATA_W = TGM_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NPINS-1:0]        pad_in,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS*PULL_W-1:0] pad_pull,
  input  logic                    jtag_activity,
  input  logic                    test_tamper,
  output logic                    backup_mode,
  output logic                    irq,
  output logic                    wakeup
);
  localparam int SYNC_W = NPINS + 2;

  // ---------------- reset: async assert, clocked release ----------------
  logic [1:0] rst_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  // ---------------- input synchronizers ----------------
  logic [SYNC_W-1:0] sync_q;
  logic [NPINS-1:0]  pad_s;
  logic              dbg_s, tst_s;

  tgm_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_ns(rst_ns),
    .d     ({test_tamper, jtag_activity, pad_in}),
    .q     (sync_q)
  );
  assign pad_s = sync_q[NPINS-1:0];
  assign dbg_s = sync_q[NPINS];
  assign tst_s = sync_q[NPINS+1];

  // ---------------- decode ----------------
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // ---------------- global registers ----------------
  logic             mode_q, mode_d;        // 1 = backup
  logic             dlock_q, dlock_d;
  logic [NPINS-1:0] detn_q, detn_d, detb_q, detb_d;
  logic [NPINS-1:0] mask_q, mask_d, wake_q, wake_d;

  always_comb begin
    mode_d  = mode_q;
    dlock_d = dlock_q;
    detn_d  = detn_q;
    detb_d  = detb_q;
    mask_d  = mask_q;
    wake_d  = wake_q;
    if (bus_wr) begin
      if (hit(bus_addr, OFF_CTRL) && bus_wdata[KEY_LSB +: 16] == MODE_KEY) begin
        if (bus_wdata[NORM_BIT])     mode_d = 1'b0;
        else if (bus_wdata[BKP_BIT]) mode_d = 1'b1;
      end
      if (hit(bus_addr, OFF_DLOCK) && bus_wdata[0]) dlock_d = 1'b1;
      if (hit(bus_addr, OFF_DETN)) detn_d = bus_wdata[PIN_LSB +: NPINS];
      if (hit(bus_addr, OFF_DETB)) detb_d = bus_wdata[PIN_LSB +: NPINS];
      if (hit(bus_addr, OFF_WAKE)) wake_d = bus_wdata[PIN_LSB +: NPINS];
      if (hit(bus_addr, OFF_MSET)) mask_d = mask_q | bus_wdata[PIN_LSB +: NPINS];
      if (hit(bus_addr, OFF_MCLR)) mask_d = mask_q & ~bus_wdata[PIN_LSB +: NPINS];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q  <= 1'b0;
      dlock_q <= 1'b0;
      detn_q  <= '0;
      detb_q  <= '0;
      mask_q  <= '0;
      wake_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      dlock_q <= dlock_d;
      detn_q  <= detn_d;
      detb_q  <= detb_d;
      mask_q  <= mask_d;
      wake_q  <= wake_d;
    end
  end

  // ---------------- per-pin configuration and filters ----------------
  logic [NPINS-1:0]  alarm_vec;
  logic [DATA_W-1:0] pin_word [NPINS];

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    tgm_pin_cfg_t cfg_q, cfg_d;
    logic         we, det_en;

    assign we = bus_wr && hit(bus_addr, OFF_PIN0 + 4 * n);

    always_comb begin
      cfg_d = cfg_q;
      if (we) begin
        cfg_d.fa   = bus_wdata[FA_LSB +: FILT_W];
        cfg_d.fb   = bus_wdata[FB_LSB +: FILT_W];
        cfg_d.dir  = bus_wdata[DIR_BIT];
        cfg_d.lvl  = bus_wdata[LVL_BIT];
        cfg_d.pull = bus_wdata[PULL_LSB +: PULL_W];
        cfg_d.dflt = bus_wdata[DFLT_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) cfg_q <= '0;
      else         cfg_q <= cfg_d;
    end

    always_comb begin
      pin_word[n]                     = '0;
      pin_word[n][FA_LSB +: FILT_W]   = cfg_q.fa;
      pin_word[n][FB_LSB +: FILT_W]   = cfg_q.fb;
      pin_word[n][DIR_BIT]            = cfg_q.dir;
      pin_word[n][LVL_BIT]            = cfg_q.lvl;
      pin_word[n][PAD_BIT]            = pad_s[n];
      pin_word[n][PULL_LSB +: PULL_W] = cfg_q.pull;
      pin_word[n][DFLT_BIT]           = cfg_q.dflt;
    end

    assign det_en = !cfg_q.dir && (mode_q ? detb_q[n] : detn_q[n]);

    tgm_pin_filter #(.FILT_W(FILT_W)) u_filt (
      .clk   (clk),
      .rst_ns(rst_ns),
      .enable(det_en),
      .level (pad_s[n]),
      .deflt (cfg_q.dflt),
      .filt  (cfg_q.fa),
      .alarm (alarm_vec[n])
    );

    assign pad_oe[n]                   = cfg_q.dir;
    assign pad_out[n]                  = cfg_q.lvl;
    assign pad_pull[n*PULL_W +: PULL_W] = cfg_q.pull;
  end

  // ---------------- status, interrupt and wake-up ----------------
  logic             clr_we;
  logic [NPINS-1:0] st_pins;
  logic             st_dbg, st_tst;

  assign clr_we = bus_wr && hit(bus_addr, OFF_CLR);

  tgm_alarm_ctrl #(.NPINS(NPINS)) u_alarm (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .pin_alarm(alarm_vec),
    .dbg_evt  (dlock_q && dbg_s),
    .tst_evt  (tst_s),
    .clr_pins (clr_we ? bus_wdata[PIN_LSB +: NPINS] : '0),
    .clr_dbg  (clr_we && bus_wdata[DBG_BIT]),
    .clr_tst  (clr_we && bus_wdata[TST_BIT]),
    .mask     (mask_q),
    .wake_en  (wake_q),
    .st_pins  (st_pins),
    .st_dbg   (st_dbg),
    .st_tst   (st_tst),
    .irq      (irq),
    .wakeup   (wakeup)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (hit(bus_addr, OFF_CTRL)) begin
      rd_d[BKP_BIT]  = mode_q;
      rd_d[NORM_BIT] = !mode_q;
    end
    if (hit(bus_addr, OFF_STAT)) begin
      rd_d[PIN_LSB +: NPINS] = st_pins;
      rd_d[DBG_BIT]          = st_dbg;
      rd_d[TST_BIT]          = st_tst;
    end
    if (hit(bus_addr, OFF_DLOCK)) rd_d[0] = dlock_q;
    if (hit(bus_addr, OFF_DETN))  rd_d[PIN_LSB +: NPINS] = detn_q;
    if (hit(bus_addr, OFF_DETB))  rd_d[PIN_LSB +: NPINS] = detb_q;
    if (hit(bus_addr, OFF_MASK))  rd_d[PIN_LSB +: NPINS] = mask_q;
    if (hit(bus_addr, OFF_WAKE))  rd_d[PIN_LSB +: NPINS] = wake_q;
    for (int n = 0; n < NPINS; n++) begin
      if (hit(bus_addr, OFF_PIN0 + 4 * n)) rd_d = pin_word[n];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign bus_rdata   = rd_q;
  assign backup_mode = mode_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[PAD_BIT], bus_wdata[11], bus_wdata[14],
                          bus_wdata[DATA_W-1:PIN_LSB+NPINS]};
endmodule

// File: rtl/tgm_checker.sv
module tgm_checker #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              mode_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  st_pins,
  input logic              st_dbg,
  input logic              dlock_q,
  input logic [NPINS-1:0]  alarm_vec,
  input logic [NPINS-1:0]  pad_oe,
  input logic              wakeup
);
  // R2: mode moves only on a keyed control write
  assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(mode_q) |-> $past(bus_wr && bus_addr == ADDR_W'('h00)
                               && bus_wdata[31:16] == 16'h89CA));

  // R8: a pin status bit drops only after a write to the clear offset
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (|($past(st_pins) & ~st_pins)) |-> $past(bus_wr && bus_addr == ADDR_W'('h10)));

  // R9: mask changes only through the set or clear offsets
  assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(mask_q) |-> $past(bus_wr && (bus_addr == ADDR_W'('h84)
                                          || bus_addr == ADDR_W'('h88))));

  // R7: an output pin never raises an alarm
  assert_no_out_alarm_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (alarm_vec & pad_oe) == '0);

  // R12: wake-up follows a pin alarm of the previous cycle
  assert_wake_cause_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    wakeup |-> $past(|alarm_vec));

  // R11: debug event latches only while the lock is set
  assert_dbg_lock_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(st_dbg) |-> $past(dlock_q));
endmodule

bind tamper_gpio_monitor tgm_checker #(
  .NPINS (NPINS),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_tgm_checker (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .mode_q   (mode_q),
  .mask_q   (mask_q),
  .st_pins  (st_pins),
  .st_dbg   (st_dbg),
  .dlock_q  (dlock_q),
  .alarm_vec(alarm_vec),
  .pad_oe   (pad_oe),
  .wakeup   (wakeup)
);

// File: tb/tamper_gpio_monitor_test.sv
module tamper_gpio_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  pad_in, pad_out, pad_oe;
  logic [15:0] pad_pull;
  logic        jtag_activity, test_tamper, backup_mode, irq, wakeup;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  tamper_gpio_monitor uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .jtag_activity(jtag_activity), .test_tamper(test_tamper),
    .backup_mode(backup_mode), .irq(irq), .wakeup(wakeup)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data one edge after capture
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(bus_rdata, 32'hDEAD_BEEF, "scoreboard underflow");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit seen;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; jtag_activity = 1'b0; test_tamper = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);

    // R1 reset state
    chk(irq, 0, "R1 irq");
    chk(pad_oe, 0, "R1 pad_oe");
    chk(backup_mode, 0, "R1 mode");
    chk(wakeup, 0, "R1 wakeup");
    rd(8'h00, 32'h2, "R1 ctrl");
    rd(8'h08, 32'h0, "R1 status");
    rd(8'h8C, 32'h0, "R1 mask");
    rd(8'h80, 32'h0, "R1 detn");
    rd(8'h7C, 32'h0, "R1 detb");
    rd(8'h90, 32'h0, "R1 wake");

    // R13 unmapped and write-only reads
    rd(8'h44, 32'h0, "R13 unmapped");
    rd(8'h84, 32'h0, "R13 mset");

    // R2 keyed mode
    wr(8'h00, 32'h1234_0001);
    rd(8'h00, 32'h2, "R2 bad key");
    chk(backup_mode, 0, "R2 bad key mode");
    wr(8'h00, 32'h89CA_0001);
    chk(backup_mode, 1, "R2 backup");
    rd(8'h00, 32'h1, "R2 backup read");
    wr(8'h00, 32'h89CA_0003);
    rd(8'h00, 32'h2, "R2 normal wins");

    // R3 pin1 fields (reserved and pad bits written but ignored)
    wr(8'h1C, 32'hFFFF_EFA5);
    rd(8'h1C, 32'h0000_A3A5, "R3 pin1 word");
    chk(pad_oe, 8'h02, "R3 pad_oe");
    chk(pad_out, 8'h02, "R3 pad_out");
    chk(pad_pull, 16'h0008, "R3 pad_pull");

    // R4 two-flop readback
    @(negedge clk); pad_in[3] = 1'b1;
    rd(8'h24, 32'h0, "R4 before sync");
    rd(8'h24, 32'h400, "R4 after sync");
    pad_in[3] = 1'b0;

    // R5 set up pin0: filter 2, input, default 0
    wr(8'h18, 32'h2);
    wr(8'h80, 32'h0001_0000);
    wr(8'h84, 32'h0001_0000);
    wr(8'h90, 32'h0001_0000);
    rd(8'h8C, 32'h0001_0000, "R9 mask set");

    // R5 short excursion
    @(negedge clk); pad_in[0] = 1'b1;
    waitn(3); pad_in[0] = 1'b0;
    waitn(8);
    chk(irq, 0, "R5 glitch");

    // R5 full excursion, due at edge 6; R12 pulse
    @(negedge clk); pad_in[0] = 1'b1;
    waitn(5);
    chk(irq, 0, "R5 early");
    chk(wakeup, 0, "R12 early");
    waitn(1);
    chk(irq, 1, "R5 due");
    chk(wakeup, 1, "R12 pulse");
    waitn(1);
    chk(wakeup, 0, "R12 one cycle");
    rd(8'h08, 32'h0001_0000, "R5 status");

    // R8 clear, R6 no re-alarm while level held
    wr(8'h10, 32'h0001_0000);
    waitn(10);
    chk(irq, 0, "R6 held level");
    rd(8'h08, 32'h0, "R8 cleared");

    // R6 re-arm after return to default
    pad_in[0] = 1'b0; waitn(4);
    pad_in[0] = 1'b1; waitn(7);
    chk(irq, 1, "R6 re-armed");

    // R9 mask clear keeps status; R10 irq follows mask
    wr(8'h88, 32'h0001_0000);
    chk(irq, 0, "R10 masked");
    rd(8'h8C, 32'h0, "R9 mask clear");
    rd(8'h08, 32'h0001_0000, "R8 still latched");
    wr(8'h84, 32'h0001_0000);
    chk(irq, 1, "R10 unmasked");
    wr(8'h10, 32'h0001_0000);
    chk(irq, 0, "R8 clear irq");

    // R7 backup mode uses 0x7C
    pad_in[0] = 1'b0; waitn(4);
    wr(8'h00, 32'h89CA_0001);
    pad_in[0] = 1'b1; waitn(10);
    chk(irq, 0, "R7 backup no enable");
    rd(8'h08, 32'h0, "R7 backup status");
    wr(8'h7C, 32'h0001_0000);
    waitn(6);
    chk(irq, 1, "R7 backup enable");
    wr(8'h10, 32'h0001_0000);
    pad_in[0] = 1'b0;
    wr(8'h00, 32'h89CA_0002);
    waitn(4);

    // R7 output pin never detects (pin1 default 1, pad low)
    wr(8'h80, 32'h0003_0000);
    wr(8'h84, 32'h0002_0000);
    waitn(45);
    chk(irq, 0, "R7 output pin");
    rd(8'h08, 32'h0, "R7 output status");

    // R11 debug lock
    jtag_activity = 1'b1; waitn(5);
    rd(8'h08, 32'h0, "R11 unlocked");
    jtag_activity = 1'b0; waitn(3);
    wr(8'h68, 32'h1);
    rd(8'h68, 32'h1, "R11 lock read");
    @(negedge clk); jtag_activity = 1'b1;
    waitn(2);
    chk(irq, 0, "R11 dbg early");
    waitn(1);
    chk(irq, 1, "R11 dbg due");
    jtag_activity = 1'b0;
    rd(8'h08, 32'h8, "R11 dbg status");
    waitn(3);
    wr(8'h10, 32'h8);
    rd(8'h08, 32'h0, "R8 dbg clear");
    wr(8'h68, 32'h0);
    rd(8'h68, 32'h1, "R11 lock sticky");

    // R11 test pin
    test_tamper = 1'b1; waitn(4);
    test_tamper = 1'b0;
    chk(irq, 1, "R11 test irq");
    rd(8'h08, 32'h4, "R11 test status");
    waitn(3);
    wr(8'h10, 32'h4);
    chk(irq, 0, "R8 test clear");

    // R12 no pulse when wake-up disabled; filter 0 due at edge 3 (R5)
    wr(8'h90, 32'h0);
    wr(8'h18, 32'h0);
    waitn(3);
    seen = 1'b0;
    @(negedge clk); pad_in[0] = 1'b1;
    waitn(2);
    chk(irq, 0, "R5 f0 early");
    seen = seen | wakeup;
    waitn(1);
    chk(irq, 1, "R5 f0 due");
    for (int i = 0; i < 6; i++) begin
      seen = seen | wakeup;
      @(negedge clk);
    end
    chk(seen, 0, "R12 disabled");

    waitn(3);
    chk(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule